// File: doc/BRIEF.md
# Receive Frame Word Formatter

This block sits between a receive byte stream and a receive DMA engine. It collects one frame of bytes, each marked as last or not, into a local buffer. It then writes that frame out as a stream of 32-bit words in two phases. The first phase is the data phase. It sends a 16-bit length prefix, then the frame bytes, then zero padding up to a word boundary. The second phase is the trailer. It sends an optional checksum word, then a receive-status word.

The length the block reports is the stored byte count plus eight, with a floor of 64. The block keeps a receive-status register and a sticky register, and it updates both when each phase ends. A one-cycle acknowledge marks the last word of each phase. While receive is disabled the block neither takes bytes nor offers words.

Top module: `rx_frame_formatter`

## Requirements
- R1: After reset, `outValid`, `phaseAck`, `rxStatus` and `rxSticky` are all zero. `inReady` follows `rxEnable`.
- R2: While `rxEnable` is low, `inReady` and `outValid` stay low. A byte offered during that time is not stored.
- R3: The first word of the data phase carries the frame length in bits [15:0]. The length is max(n + 8, 64), where n is the stored byte count.
- R4: Stream byte position p sits in word p/4 at bits [8*(p%4)+7 : 8*(p%4)]. Frame byte i sits at position i + 2.
- R5: Positions past the last frame byte are zero up to the next multiple of four. The data phase is exactly ceil((n + 2) / 4) words long.
- R6: When the data phase ends, the status register is updated: bits [11:0] take the length, and bit 12 (accept) and bit 13 (complete) are set. Sticky bit 13 is also set. All other bits keep their values.
- R7: `csumEnable` is sampled when the data phase ends. If it is high, the trailer is the `checkValue` captured with the last byte, followed by the status word. If it is low, the trailer is the status word alone. The status word equals the status register with bit 14 (OK) set. Once it is taken, status bit 14 and sticky bit 14 are set.
- R8: `phaseAck` pulses for one cycle, only on the handshake of the last word of each phase. The data phase and the trailer alternate strictly, and no new byte is taken until the trailer is done.
- R9: While `outValid` is high and `outReady` is low, `outWord` holds its value and `outValid` stays high.
- R10: A rising edge of `rxEnable` clears status bit 13 and leaves the sticky register unchanged.
- R11: Bytes beyond `MAX_BYTES` in a single frame are dropped, and the reported length uses `MAX_BYTES`.
- R12: `inReady` and `outValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receive enable |
| csumEnable | input | 1 | Adds the checksum word to the trailer |
| checkValue | input | 32 | Checksum value, captured with the last byte |
| inByte | input | 8 | Received byte |
| inValid | input | 1 | `inByte` is valid |
| inLast | input | 1 | Marks the last byte of the frame |
| inReady | output | 1 | The block takes a byte this cycle |
| outWord | output | 32 | Word for the DMA side, little-endian |
| outValid | output | 1 | `outWord` is valid |
| outReady | input | 1 | The DMA side takes the word |
| phaseAck | output | 1 | Marks the last word of a phase |
| rxStatus | output | 32 | Receive-status register |
| rxSticky | output | 32 | Sticky completion bits |

## Verification
The assertions take two things for granted about the environment. First, `rxEnable` does not fall while a word is being offered and stalled. Second, `checkValue` is valid together with the byte that carries `inLast`. The stimulus respects both. It changes `rxEnable` only between frames, and it drives `checkValue` for the whole frame. Frames always end with a marked byte, and stalls are inserted only on the DMA side, so the hold property on stalled words is exercised without breaking either assumption.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
  localparam int LEN_W     = 12;
  localparam int ACC_BIT   = 12;
  localparam int CMP_BIT   = 13;
  localparam int OK_BIT    = 14;
  localparam int MIN_LEN   = 64;
  localparam int LEN_EXTRA = 8;

  typedef enum logic [1:0] {FMT_COLLECT, FMT_DATA, FMT_CSUM, FMT_STAT} fmtState_t;
  typedef enum logic [1:0] {SEL_DATA, SEL_CSUM, SEL_STAT} wordSel_t;

  typedef struct packed {
    logic     takeByte;
    logic     lastByte;
    logic     dataFire;
    logic     dataDone;
    logic     trailDone;
    logic     enRise;
    wordSel_t sel;
  } fmtStrobe_t;
endpackage

// File: rtl/rxfmt_ctrl.sv
module rxfmt_ctrl
  import rxfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEnable,
  input  logic       csumEnable,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       outReady,
  input  logic       lastWord,
  output fmtStrobe_t strobe,
  output logic       inReady,
  output logic       outValid,
  output logic       phaseAck
);
  fmtState_t state, nextState;
  logic      enPrev;
  logic      fire;

  always_comb begin
    strobe        = '0;
    nextState     = state;
    inReady       = 1'b0;
    outValid      = 1'b0;
    strobe.enRise = rxEnable & ~enPrev;
    fire          = rxEnable & outReady;
    case (state)
      FMT_COLLECT: begin
        inReady         = rxEnable;
        strobe.takeByte = inValid & rxEnable;
        strobe.lastByte = inValid & rxEnable & inLast;
        if (strobe.lastByte) nextState = FMT_DATA;
      end
      FMT_DATA: begin
        outValid   = rxEnable;
        strobe.sel = SEL_DATA;
        if (fire) begin
          strobe.dataFire = 1'b1;
          if (lastWord) begin
            strobe.dataDone = 1'b1;
            nextState       = csumEnable ? FMT_CSUM : FMT_STAT;
          end
        end
      end
      FMT_CSUM: begin
        outValid   = rxEnable;
        strobe.sel = SEL_CSUM;
        if (fire) nextState = FMT_STAT;
      end
      FMT_STAT: begin
        outValid   = rxEnable;
        strobe.sel = SEL_STAT;
        if (fire) begin
          strobe.trailDone = 1'b1;
          nextState        = FMT_COLLECT;
        end
      end
      default: nextState = FMT_COLLECT;
    endcase
    phaseAck = strobe.dataDone | strobe.trailDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FMT_COLLECT;
      enPrev <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= rxEnable;
    end
  end
endmodule

// File: rtl/rxfmt_datapath.sv
module rxfmt_datapath
  import rxfmt_pkg::*;
#(
  parameter int MAX_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fmtStrobe_t  strobe,
  input  logic [7:0]  inByte,
  input  logic [31:0] checkValue,
  output logic        lastWord,
  output logic [31:0] outWord,
  output logic [31:0] rxStatus,
  output logic [31:0] rxSticky
);
  localparam int CNT_W  = $clog2(MAX_BYTES + 1);
  localparam int IDX_W  = $clog2(MAX_BYTES);
  localparam int POS_W  = CNT_W + 2;
  localparam int WIDX_W = $clog2((MAX_BYTES + 5) / 4 + 1);

  logic [7:0]        frameMem [MAX_BYTES];
  logic [CNT_W-1:0]  byteCount;
  logic [WIDX_W-1:0] wordIdx, numWords;
  logic [31:0]       csumReg, statusNext, stickyNext, dataWord;
  logic [LEN_W-1:0]  lenSum, frameLen;
  logic [15:0]       lenWide;
  logic              roomLeft;

  assign roomLeft = byteCount < CNT_W'(MAX_BYTES);
  assign lenSum   = LEN_W'(byteCount) + LEN_W'(LEN_EXTRA);
  assign frameLen = (lenSum < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : lenSum;
  assign lenWide  = 16'(frameLen);
  assign numWords = WIDX_W'((POS_W'(byteCount) + POS_W'(5)) >> 2);
  assign lastWord = (wordIdx == numWords - WIDX_W'(1));

  always_ff @(posedge clk) begin
    if (strobe.takeByte && roomLeft) frameMem[byteCount[IDX_W-1:0]] <= inByte;
  end

  // Each lane picks prefix, stored byte or zero pad by its stream position.
  always_comb begin
    dataWord = '0;
    for (int b = 0; b < 4; b++) begin
      logic [POS_W-1:0] pos, rel;
      pos = (POS_W'(wordIdx) << 2) + POS_W'(b);
      rel = pos - POS_W'(2);
      if (pos == POS_W'(0))      dataWord[8*b +: 8] = lenWide[7:0];
      else if (pos == POS_W'(1)) dataWord[8*b +: 8] = lenWide[15:8];
      else if (rel < POS_W'(byteCount)) dataWord[8*b +: 8] = frameMem[rel[IDX_W-1:0]];
    end
  end

  always_comb begin
    statusNext = rxStatus;
    stickyNext = rxSticky;
    if (strobe.enRise) statusNext[CMP_BIT] = 1'b0;
    if (strobe.dataDone) begin
      statusNext[LEN_W-1:0] = frameLen;
      statusNext[ACC_BIT]   = 1'b1;
      statusNext[CMP_BIT]   = 1'b1;
      stickyNext[CMP_BIT]   = 1'b1;
    end
    if (strobe.trailDone) begin
      statusNext[OK_BIT] = 1'b1;
      stickyNext[OK_BIT] = 1'b1;
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_CSUM: outWord = csumReg;
      SEL_STAT: outWord = rxStatus | (32'd1 << OK_BIT);
      default:  outWord = dataWord;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCount <= '0;
      wordIdx   <= '0;
      csumReg   <= '0;
      rxStatus  <= '0;
      rxSticky  <= '0;
    end else begin
      if (strobe.trailDone) byteCount <= '0;
      else if (strobe.takeByte && roomLeft) byteCount <= byteCount + CNT_W'(1);
      if (strobe.lastByte) csumReg <= checkValue;
      if (strobe.dataDone) wordIdx <= '0;
      else if (strobe.dataFire) wordIdx <= wordIdx + WIDX_W'(1);
      rxStatus <= statusNext;
      rxSticky <= stickyNext;
    end
  end
endmodule

// File: rtl/rx_frame_formatter.sv
module rx_frame_formatter
  import rxfmt_pkg::*;
#(
  parameter int MAX_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxEnable,
  input  logic        csumEnable,
  input  logic [31:0] checkValue,
  input  logic [7:0]  inByte,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic [31:0] outWord,
  output logic        outValid,
  input  logic        outReady,
  output logic        phaseAck,
  output logic [31:0] rxStatus,
  output logic [31:0] rxSticky
);
  fmtStrobe_t strobe;
  logic       lastWord;

  rxfmt_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .csumEnable(csumEnable),
    .inValid(inValid), .inLast(inLast), .outReady(outReady), .lastWord(lastWord),
    .strobe(strobe), .inReady(inReady), .outValid(outValid), .phaseAck(phaseAck)
  );

  rxfmt_datapath #(.MAX_BYTES(MAX_BYTES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inByte(inByte),
    .checkValue(checkValue), .lastWord(lastWord), .outWord(outWord),
    .rxStatus(rxStatus), .rxSticky(rxSticky)
  );
endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rxEnable,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outWord,
  input logic        phaseAck,
  input logic [31:0] rxStatus,
  input logic [31:0] rxSticky
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |-> (!outValid && !inReady));
  // R12
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inReady, outValid}));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> ($stable(outWord) && outValid));
  // R8
  ack_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phaseAck |-> (outValid && outReady));
  // R6
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phaseAck |=> rxSticky[13]);
  // R3
  len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxStatus[12] |-> (rxStatus[11:0] >= 12'd64));
  // R7
  ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxSticky[14] |=> rxSticky[14]);
endmodule

bind rx_frame_formatter rxfmt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outWord(outWord),
  .phaseAck(phaseAck), .rxStatus(rxStatus), .rxSticky(rxSticky)
);

// File: tb/rx_frame_formatter_tb_top.sv
`timescale 1ns/1ps
module rx_frame_formatter_tb_top;
  localparam int MAXB = 256;
  localparam logic [31:0] ACC = 32'h1000, CMP = 32'h2000, OKB = 32'h4000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, rxEnable, csumEnable, inValid, inLast, inReady;
  logic        outValid, outReady, phaseAck;
  logic [7:0]  inByte;
  logic [31:0] checkValue, outWord, rxStatus, rxSticky;

  rx_frame_formatter #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .csumEnable(csumEnable),
    .checkValue(checkValue), .inByte(inByte), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outWord(outWord), .outValid(outValid), .outReady(outReady),
    .phaseAck(phaseAck), .rxStatus(rxStatus), .rxSticky(rxSticky)
  );

  int total = 0, bad = 0;
  logic [7:0]  frm [0:511];
  logic [31:0] expStat = '0, expSticky = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input int n, input int seed, input logic [31:0] cv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1; inByte = 8'(i * 7 + seed); inLast = (i == n - 1); checkValue = cv;
      if (i < 512) frm[i] = 8'(i * 7 + seed);
      while (!inReady) @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic getWord(input int stall, output logic [31:0] w, output logic ack);
    logic [31:0] w0;
    @(negedge clk);
    outReady = 1'b0;
    while (!outValid) @(negedge clk);
    w0 = outWord;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(outValid && outWord == w0, "R9", outWord, w0);
    end
    check(!inReady, "R12", 32'(inReady), 32'd0);
    outReady = 1'b1;
    #1;
    w = outWord; ack = phaseAck;
  endtask

  task automatic runFrame(input int n, input int seed, input bit csum, input int stall, input logic [31:0] cv);
    int effN, len, nw;
    logic [31:0] w, expW;
    logic ack;
    logic [7:0] bv;
    effN = (n > MAXB) ? MAXB : n;
    len = (effN + 8 < 64) ? 64 : effN + 8;
    nw = (effN + 5) / 4;
    csumEnable = csum;
    sendFrame(n, seed, cv);
    for (int k = 0; k < nw; k++) begin
      getWord(stall, w, ack);
      expW = '0;
      for (int b = 0; b < 4; b++) begin
        int p;
        p = 4 * k + b;
        if (p == 0) bv = 8'(len);
        else if (p == 1) bv = 8'(len >> 8);
        else if (p - 2 < effN) bv = frm[p - 2];
        else bv = 8'h00;
        expW[8*b +: 8] = bv;
      end
      check(w == expW, (k == 0) ? "R3" : ((k == nw - 1) ? "R5" : "R4"), w, expW);
      check(ack == (k == nw - 1), "R8", 32'(ack), 32'(k == nw - 1));
    end
    @(negedge clk);
    outReady = 1'b0;
    expStat = (expStat & ~32'hFFF) | 32'(len) | ACC | CMP;
    expSticky = expSticky | CMP;
    check(rxStatus == expStat, (n > MAXB) ? "R11" : "R6", rxStatus, expStat);
    check(rxSticky == expSticky, "R6", rxSticky, expSticky);
    check(outValid, "R8", 32'(outValid), 32'd1);
    if (csum) begin
      getWord(stall, w, ack);
      check(w == cv, "R7", w, cv);
      check(!ack, "R8", 32'(ack), 32'd0);
    end
    getWord(stall, w, ack);
    check(w == (expStat | OKB), "R7", w, expStat | OKB);
    check(ack, "R8", 32'(ack), 32'd1);
    @(negedge clk);
    outReady = 1'b0;
    expStat = expStat | OKB;
    expSticky = expSticky | OKB;
    check(rxStatus == expStat, "R7", rxStatus, expStat);
    check(rxSticky == expSticky, "R7", rxSticky, expSticky);
    check(!outValid && inReady, "R8", {30'd0, outValid, inReady}, 32'd1);
  endtask

  task automatic resetTest();
    rst_n = 1'b0; rxEnable = 1'b1; csumEnable = 1'b0; checkValue = '0;
    inByte = '0; inValid = 1'b0; inLast = 1'b0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!outValid && !phaseAck, "R1", {30'd0, outValid, phaseAck}, 32'd0);
    check(rxStatus == 32'd0, "R1", rxStatus, 32'd0);
    check(rxSticky == 32'd0, "R1", rxSticky, 32'd0);
    check(inReady, "R1", 32'(inReady), 32'd1);
  endtask

  task automatic disableTest();
    @(negedge clk);
    rxEnable = 1'b0; inValid = 1'b1; inByte = 8'hAA; inLast = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!inReady && !outValid, "R2", {30'd0, inReady, outValid}, 32'd0);
    end
    inValid = 1'b0; inLast = 1'b0;
    check(rxStatus == expStat, "R2", rxStatus, expStat);
    rxEnable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expStat = expStat & ~CMP;
    check(rxStatus == expStat, "R10", rxStatus, expStat);
    check(rxSticky == expSticky, "R10", rxSticky, expSticky);
    runFrame(5, 3, 1'b0, 0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    resetTest();
    runFrame(10, 1, 1'b0, 0, 32'h0);
    runFrame(60, 9, 1'b1, 2, 32'hDEADBEEF);
    runFrame(57, 4, 1'b0, 0, 32'h0);
    runFrame(56, 2, 1'b1, 0, 32'h12345678);
    runFrame(1, 5, 1'b0, 1, 32'h0);
    runFrame(2, 6, 1'b0, 0, 32'h0);
    runFrame(3, 8, 1'b1, 0, 32'hCAFEF00D);
    runFrame(300, 11, 1'b0, 0, 32'h0);
    disableTest();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule